// File: doc/BRIEF.md
# Branch-on-Bit Bus Sequencer

This block runs the bus cycles of a single branch-on-bit instruction. The instruction tests one bit of a byte in the zero page and, depending on the result, branches relative to the program counter. A pulse on `start_i` with an address on `pc_i` starts the sequence. The block then reads the opcode, the zero-page pointer, the zero-page byte (read twice), and the signed branch offset. It adds one bus cycle when the branch is taken, and one more when the target lies in a different 256-byte page. Every access appears on `addr_o` with `rd_o` high, so the whole access trace can be seen at the ports.

The opcode chooses the tested bit and the branch sense. When the last bus cycle completes, the block returns to idle and pulses `done_o` for one cycle. In that cycle `pc_o` carries the address of the next instruction and `taken_o` carries the branch decision.

Top module: `bbx_seq`

## Requirements
- R1: `start_i` in idle starts a sequence whose first bus cycle reads `pc_i`, with `sync_o` high only in that cycle. `start_i` is ignored while `busy_o` is high.
- R2: The second bus cycle reads address `pc+1`. The byte returned is the zero-page pointer.
- R3: The third and fourth bus cycles both read address `{8'h00, pointer}`. Only the third read supplies the tested byte; the data returned by the fourth read has no effect.
- R4: The fifth bus cycle reads address `pc+2`. The byte returned is the signed 8-bit branch offset.
- R5: Opcode bits [6:4] give the index of the tested bit. Opcode bit 7 set means branch if the bit is 1; bit 7 clear means branch if the bit is 0.
- R6: A branch that is not taken uses exactly 5 bus cycles and ends with `pc_o = pc+3` and `taken_o = 0`.
- R7: A taken branch reads `pc+3` in a sixth bus cycle and ends with `taken_o = 1` and `pc_o = pc+3+sign_extend(offset)`.
- R8: A taken branch whose target differs from `pc+3` in bits [15:8] adds a seventh bus cycle. That cycle reads `{(pc+3)[15:8], target[7:0]}`. All address arithmetic wraps modulo 2^16.
- R9: `done_o` is a one-cycle pulse in the cycle after the last bus cycle, with `rd_o` low and `pc_o` and `taken_o` valid.
- R10: After reset, `rd_o`, `busy_o`, `done_o`, `taken_o` and `pc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sequence (accepted in idle only) |
| pc_i | input | 16 | Address of the opcode |
| rdata_i | input | 8 | Read data bus |
| addr_o | output | 16 | Bus address |
| rd_o | output | 1 | Bus read strobe |
| sync_o | output | 1 | Marks the opcode fetch cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision, valid with `done_o` |
| pc_o | output | 16 | Next instruction address, valid with `done_o` |

## Verification
A wrong state step shows up on `addr_o` in the very next bus cycle. Examples are a missing repeated zero-page read, or a penalty cycle that is skipped or inserted. It also changes the trace length by one, which `done_o` exposes at most two cycles later.

A latch error causes a wrong decision or wrong target address. Examples are testing the byte from the dummy read, or dropping the offset sign. The error is visible in `taken_o`, `pc_o` or the penalty-cycle address by the end of the sequence.

Feeding different data on the repeated read separates the two zero-page reads.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ZPA,
    ST_ZRD1,
    ST_ZRD2,
    ST_OFS,
    ST_TKN,
    ST_PGX
  } bbx_state_e;
endpackage

// File: rtl/bbx_ctrl.sv
module bbx_ctrl
  import bbx_pkg::*;
#(
  parameter int MAX_BUS = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       taken_i,
  input  logic       cross_i,
  output bbx_state_e state_o,
  output logic       accept_o,
  output logic       finish_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(MAX_BUS + 2);

  bbx_state_e state_q, state_d;
  logic       done_q;
  logic [CNT_W-1:0] bus_cnt_q;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_OPC;
      ST_OPC:  state_d = ST_ZPA;
      ST_ZPA:  state_d = ST_ZRD1;
      ST_ZRD1: state_d = ST_ZRD2;
      ST_ZRD2: state_d = ST_OFS;
      ST_OFS: begin
        if (taken_i) state_d = ST_TKN;
        else begin
          state_d  = ST_IDLE;
          finish_o = 1'b1;
        end
      end
      ST_TKN: begin
        if (cross_i) state_d = ST_PGX;
        else begin
          state_d  = ST_IDLE;
          finish_o = 1'b1;
        end
      end
      ST_PGX: begin
        state_d  = ST_IDLE;
        finish_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      bus_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_o;
      if (state_q == ST_IDLE) bus_cnt_q <= '0;
      else                    bus_cnt_q <= bus_cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_BUS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bus_cnt_q < CNT_W'(MAX_BUS))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o || $past(start_i)); // R9
endmodule

// File: rtl/bbx_dpath.sv
module bbx_dpath
  import bbx_pkg::*;
#(
  parameter int             AW       = 16,
  parameter int             DW       = 8,
  parameter int             SEL_LSB  = 4,
  parameter logic [AW-DW-1:0] ZP_PAGE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bbx_state_e    state_i,
  input  logic          accept_i,
  input  logic          finish_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] rdata_i,
  output logic          taken_o,
  output logic          cross_o,
  output logic [AW-1:0] pc_base_o,
  output logic [AW-1:0] zp_addr_o,
  output logic [AW-1:0] next_pc_o,
  output logic [AW-1:0] target_o,
  output logic          res_taken_o,
  output logic [AW-1:0] res_pc_o
);
  localparam int BIT_W  = $clog2(DW);
  localparam int PAGE_W = AW - DW;
  localparam logic [AW-1:0] INSN_LEN = AW'(3);

  logic [AW-1:0]    pc_q;
  logic [BIT_W-1:0] bitsel_q;
  logic             sense_q;
  logic [DW-1:0]    zp_q, val_q, off_q;
  logic             res_taken_q;
  logic [AW-1:0]    res_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= '0;
      bitsel_q    <= '0;
      sense_q     <= 1'b0;
      zp_q        <= '0;
      val_q       <= '0;
      off_q       <= '0;
      res_taken_q <= 1'b0;
      res_pc_q    <= '0;
    end else begin
      if (accept_i) pc_q <= pc_i;
      unique case (state_i)
        ST_OPC: begin
          bitsel_q <= rdata_i[SEL_LSB +: BIT_W];
          sense_q  <= rdata_i[DW-1];
        end
        ST_ZPA:  zp_q  <= rdata_i;
        ST_ZRD1: val_q <= rdata_i;
        ST_OFS:  off_q <= rdata_i;
        default: ;
      endcase
      if (finish_i) begin
        res_taken_q <= taken_o;
        res_pc_q    <= taken_o ? target_o : next_pc_o;
      end
    end
  end

  // decision depends only on bits latched before the offset fetch
  assign taken_o   = (val_q[bitsel_q] == sense_q);
  assign pc_base_o = pc_q;
  assign zp_addr_o = {ZP_PAGE, zp_q};
  assign next_pc_o = pc_q + INSN_LEN;
  assign target_o  = next_pc_o + {{PAGE_W{off_q[DW-1]}}, off_q};
  assign cross_o   = (target_o[AW-1:DW] != next_pc_o[AW-1:DW]);

  assign res_taken_o = res_taken_q;
  assign res_pc_o    = res_pc_q;

  AST_ZP_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZRD2) |=> (val_q == $past(val_q))); // R3
endmodule

// File: rtl/bbx_addr_mux.sv
module bbx_addr_mux
  import bbx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bbx_state_e    state_i,
  input  logic [AW-1:0] pc_base_i,
  input  logic [AW-1:0] zp_addr_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          sync_o
);
  always_comb begin
    addr_o = '0;
    unique case (state_i)
      ST_OPC:           addr_o = pc_base_i;
      ST_ZPA:           addr_o = pc_base_i + AW'(1);
      ST_ZRD1, ST_ZRD2: addr_o = zp_addr_i;
      ST_OFS:           addr_o = pc_base_i + AW'(2);
      ST_TKN:           addr_o = next_pc_i;
      // uncorrected address: old page, new low byte
      ST_PGX:           addr_o = {next_pc_i[AW-1:DW], target_i[DW-1:0]};
      default:          addr_o = '0;
    endcase
  end

  assign rd_o   = (state_i != ST_IDLE);
  assign sync_o = (state_i == ST_OPC);

  AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o && rd_o); // R1
  AST_ZP_TWICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZRD2) |-> (addr_o == $past(addr_o))); // R3
  AST_OFS_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OFS) |-> (addr_o == $past(addr_o, 3) + AW'(1))); // R4
endmodule

// File: rtl/bbx_seq.sv
module bbx_seq
  import bbx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          sync_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          taken_o,
  output logic [AW-1:0] pc_o
);
  localparam int SEL_LSB = DW / 2;
  localparam int MAX_BUS = 7;

  bbx_state_e    state;
  logic          accept, finish, br_taken, br_cross;
  logic [AW-1:0] pc_base, zp_addr, next_pc, target;

  bbx_ctrl #(.MAX_BUS(MAX_BUS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .taken_i  (br_taken),
    .cross_i  (br_cross),
    .state_o  (state),
    .accept_o (accept),
    .finish_o (finish),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  bbx_dpath #(.AW(AW), .DW(DW), .SEL_LSB(SEL_LSB), .ZP_PAGE('0)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .accept_i    (accept),
    .finish_i    (finish),
    .pc_i        (pc_i),
    .rdata_i     (rdata_i),
    .taken_o     (br_taken),
    .cross_o     (br_cross),
    .pc_base_o   (pc_base),
    .zp_addr_o   (zp_addr),
    .next_pc_o   (next_pc),
    .target_o    (target),
    .res_taken_o (taken_o),
    .res_pc_o    (pc_o)
  );

  bbx_addr_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .pc_base_i (pc_base),
    .zp_addr_i (zp_addr),
    .next_pc_i (next_pc),
    .target_i  (target),
    .addr_o    (addr_o),
    .rd_o      (rd_o),
    .sync_o    (sync_o)
  );

  AST_START_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (sync_o && addr_o == $past(pc_i))); // R1
  AST_DONE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_o || $past(start_i))); // R9
endmodule

// File: tb/bbx_seq_tb_top.sv
`timescale 1ns/1ps
module bbx_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  rdata_i = '0;
  logic [15:0] addr_o, pc_o;
  logic        rd_o, sync_o, busy_o, done_o, taken_o;

  int errors = 0;
  int checks = 0;
  bit ended = 1'b0;

  always #10ns clk_i = ~clk_i;

  bbx_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pc_i(pc_i),
    .rdata_i(rdata_i), .addr_o(addr_o), .rd_o(rd_o), .sync_o(sync_o),
    .busy_o(busy_o), .done_o(done_o), .taken_o(taken_o), .pc_o(pc_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one instruction; expectations derived from R2..R9
  task automatic run_case(input string tag, input logic [15:0] pc,
                          input logic [7:0] opc, input logic [7:0] zp,
                          input logic [7:0] zval, input logic [7:0] off,
                          input bit alt, input bit poke, input int exp_n);
    logic [15:0] nxt, tgt, zpa, a;
    logic [15:0] exp_tr [8];
    logic [15:0] tr [8];
    bit tk, cr;
    int n, k;
    nxt = pc + 16'd3;
    tgt = nxt + {{8{off[7]}}, off};
    zpa = {8'h00, zp};
    tk  = (zval[opc[6:4]] == opc[7]);   // R5
    cr  = (tgt[15:8] != nxt[15:8]);
    n   = 5 + int'(tk) + int'(tk && cr);
    exp_tr[0] = pc; exp_tr[1] = pc + 16'd1; exp_tr[2] = zpa; exp_tr[3] = zpa;
    exp_tr[4] = pc + 16'd2; exp_tr[5] = nxt; exp_tr[6] = {nxt[15:8], tgt[7:0]};
    exp_tr[7] = '0;
    for (int i = 0; i < 8; i++) tr[i] = '0;
    chk(n == exp_n, "R5", {tag, " scenario length"}, n, exp_n);

    @(negedge clk_i);
    start_i = 1'b1; pc_i = pc;
    @(negedge clk_i);
    start_i = 1'b0; pc_i = 16'h0;
    k = 0;
    while (rd_o === 1'b1 && k < 10) begin
      a = addr_o;
      if (k < 8) tr[k] = a;
      chk(sync_o == (k == 0), "R1", {tag, " sync marker"}, sync_o, (k == 0));
      if (a == pc) rdata_i = opc;
      else if (a == pc + 16'd1) rdata_i = zp;
      else if (a == pc + 16'd2) rdata_i = off;
      else if (a == zpa) rdata_i = (k == 3 && alt) ? ~zval : zval;
      else rdata_i = a[7:0] ^ 8'hA5;
      if (poke && k == 2) begin start_i = 1'b1; pc_i = 16'h9999; end
      else begin start_i = 1'b0; pc_i = 16'h0; end
      k++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(k == n, tk ? (cr ? "R8" : "R7") : "R6", {tag, " bus cycles"}, k, n);
    for (int i = 0; i < 8; i++)
      if (i < n)
        chk(tr[i] == exp_tr[i], (i < 2) ? "R2" : (i < 4) ? "R3" : (i < 5) ? "R4" : "R8",
            $sformatf("%s addr[%0d]", tag, i), tr[i], exp_tr[i]);
    chk(done_o == 1'b1, "R9", {tag, " done pulse"}, done_o, 1);
    chk(rd_o == 1'b0, "R9", {tag, " rd low at done"}, rd_o, 0);
    chk(taken_o == tk, "R5", {tag, " taken"}, taken_o, tk);
    chk(pc_o == (tk ? tgt : nxt), tk ? "R7" : "R6", {tag, " next pc"}, pc_o, tk ? tgt : nxt);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9", {tag, " done one cycle"}, done_o, 0);
    chk(busy_o == 1'b0, "R1", {tag, " no restart from ignored start"}, busy_o, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #35ns;
    chk(rd_o == 0, "R10", "reset rd", rd_o, 0);
    chk(busy_o == 0, "R10", "reset busy", busy_o, 0);
    chk(done_o == 0, "R10", "reset done", done_o, 0);
    chk(taken_o == 0, "R10", "reset taken", taken_o, 0);
    chk(pc_o == 0, "R10", "reset pc", pc_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #4ms;
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R6: bit 0 clear test on a set bit, not taken
    run_case("nt_clr0", 16'h1000, 8'h0F, 8'h40, 8'h01, 8'h10, 1'b0, 1'b0, 5);
    // R7: bit 7 set test, forward, same page
    run_case("tk_set7", 16'h2000, 8'hFF, 8'h41, 8'h80, 8'h10, 1'b0, 1'b0, 6);
    // R8: bit 3 clear test, backward across page
    run_case("tk_clr3_back", 16'h3010, 8'h3F, 8'h42, 8'hF7, 8'h80, 1'b0, 1'b0, 7);
    // R3: dummy read data would make it taken; must not
    run_case("nt_set5_alt", 16'h1234, 8'hDF, 8'h43, 8'h00, 8'h05, 1'b1, 1'b0, 5);
    // R8 wrap plus R1 start ignored while busy
    run_case("tk_clr2_wrap", 16'hFFF0, 8'h2F, 8'h44, 8'hFB, 8'h7F, 1'b0, 1'b1, 7);
    // R3: dummy read would clear the bit; still taken
    run_case("tk_set1_alt", 16'h4080, 8'h9F, 8'h45, 8'h02, 8'h05, 1'b1, 1'b0, 6);
    // R5: bit 6 clear test on a clear bit, backward same page
    run_case("tk_clr6", 16'h5050, 8'h6F, 8'h46, 8'hBF, 8'hF0, 1'b0, 1'b0, 6);
    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule